// File: doc/BRIEF.md
# Bit-Slice ALU with Compare Chain

This block is a purely combinational arithmetic and logic unit for two unsigned operands of a parameterised width, eight bits by default. A 3-bit operation code selects one of eight functions:

- addition and subtraction;
- four bitwise functions: AND, OR, NOR and NAND;
- equality and inequality tests.

The unit is built from one-bit slices placed side by side. Each slice passes two signals to the slice above it: a ripple carry and a running "all bits equal so far" signal.

A shared decoder turns the operation code into slice controls. For subtraction, every slice inverts its B bit and the carry into the lowest slice is forced high. For the two compare codes, a finishing stage turns the top of the equality chain into a single flag. That flag is driven on its own output and also placed in bit 0 of the result word. The carry out of the top slice is passed on only for the two arithmetic codes.

The unit is meant to sit in a datapath where a registered operation code and operands feed it. Its outputs settle within the same cycle.

Top module: `bitslice_alu`

## Requirements
- R1: Code 001 (add): {carry_out, result} equals opnd_a + opnd_b as an unsigned sum one bit wider than the operands.
- R2: Code 101 (subtract): result equals opnd_a - opnd_b modulo 2^W. carry_out is 1 exactly when opnd_a >= opnd_b unsigned, meaning no borrow.
- R3: Code 010 gives the bitwise AND of the operands in result; code 011 gives the bitwise OR.
- R4: Code 110 gives the bitwise NOR of the operands in result; code 111 gives the bitwise NAND.
- R5: Code 100 (equal): cmp_flag is 1 exactly when opnd_a == opnd_b. result bit 0 equals cmp_flag and result bits W-1..1 are 0.
- R6: Code 000 (not equal): cmp_flag is 1 exactly when opnd_a != opnd_b. result bit 0 equals cmp_flag and result bits W-1..1 are 0.
- R7: carry_out is 0 for every code other than 001 and 101.
- R8: cmp_flag is 0 for every code other than 000 and 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation select: 000 NEQ, 001 ADD, 010 AND, 011 OR, 100 EQ, 101 SUB, 110 NOR, 111 NAND |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| result | output | W | Result word |
| carry_out | output | 1 | Carry from the top slice for ADD and SUB, otherwise 0 |
| cmp_flag | output | 1 | Equality result for EQ and NEQ, otherwise 0 |

## Verification
The bench pushes the carry through every slice with all-ones plus one. A chain that breaks anywhere shows up as a wrong sum or a missing carry_out.

Subtractions are run on both sides of the borrow point. A design that drops the forced carry-in is then off by one, and a design with the borrow sense inverted flips carry_out.

Compare codes are run on operands that differ only in the top bit or only in the lowest bit. A break in the equality chain, or an inverted NEQ, then gives the wrong flag. Stray upper result bits on EQ and NEQ, and a leaked carry or flag on the logic codes, are checked at the ports on inputs chosen so that a leak would be visible.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  typedef enum logic [2:0] {
    OP_NEQ  = 3'b000,
    OP_ADD  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_EQ   = 3'b100,
    OP_SUB  = 3'b101,
    OP_NOR  = 3'b110,
    OP_NAND = 3'b111
  } op_e;

  // Which slice output feeds the result word.
  typedef enum logic [1:0] {
    K_ARITH = 2'd0,
    K_LOGIC = 2'd1,
    K_CMP   = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    L_AND  = 2'd0,
    L_OR   = 2'd1,
    L_NOR  = 2'd2,
    L_NAND = 2'd3
  } lfn_e;

  typedef struct packed {
    kind_e kind;
    logic  inv_b;    // invert B in every slice and force carry-in high
    lfn_e  lfn;
    logic  cmp_inv;  // invert the equality chain result (NEQ)
  } ctrl_t;

endpackage

// File: rtl/bsalu_decode.sv
module bsalu_decode
  import bsalu_pkg::*;
(
  input  logic [2:0] op_code,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl.kind    = K_LOGIC;
    ctrl.inv_b   = 1'b0;
    ctrl.lfn     = L_AND;
    ctrl.cmp_inv = 1'b0;
    case (op_code)
      OP_ADD: ctrl.kind = K_ARITH;
      OP_SUB: begin
        ctrl.kind  = K_ARITH;
        ctrl.inv_b = 1'b1;
      end
      OP_AND:  ctrl.lfn = L_AND;
      OP_OR:   ctrl.lfn = L_OR;
      OP_NOR:  ctrl.lfn = L_NOR;
      OP_NAND: ctrl.lfn = L_NAND;
      OP_EQ:   ctrl.kind = K_CMP;
      OP_NEQ: begin
        ctrl.kind    = K_CMP;
        ctrl.cmp_inv = 1'b1;
      end
      default: ctrl.kind = K_LOGIC;
    endcase
  end

endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
  import bsalu_pkg::*;
(
  input  logic  a_bit,
  input  logic  b_bit,
  input  kind_e kind,
  input  logic  inv_b,
  input  lfn_e  lfn,
  input  logic  carry_in,
  input  logic  eq_in,
  output logic  r_bit,
  output logic  carry_nxt,
  output logic  eq_nxt
);

  logic b_eff;
  logic half;
  logic sum;
  logic lval;

  always_comb begin
    b_eff     = b_bit ^ inv_b;
    half      = a_bit ^ b_eff;
    sum       = half ^ carry_in;
    carry_nxt = (a_bit & b_eff) | (carry_in & half);
    // Equality uses the raw B bit, independent of the subtract inversion.
    eq_nxt    = eq_in & ~(a_bit ^ b_bit);

    case (lfn)
      L_AND:   lval = a_bit & b_bit;
      L_OR:    lval = a_bit | b_bit;
      L_NOR:   lval = ~(a_bit | b_bit);
      L_NAND:  lval = ~(a_bit & b_bit);
      default: lval = 1'b0;
    endcase

    case (kind)
      K_ARITH: r_bit = sum;
      K_LOGIC: r_bit = lval;
      default: r_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/bsalu_finish.sv
module bsalu_finish
  import bsalu_pkg::*;
#(
  parameter int W = 8
) (
  input  kind_e          kind,
  input  logic           cmp_inv,
  input  logic [W-1:0]   slice_r,
  input  logic           top_carry,
  input  logic           eq_chain,
  output logic [W-1:0]   result,
  output logic           carry_out,
  output logic           cmp_flag
);

  logic is_cmp;

  always_comb begin
    is_cmp    = (kind == K_CMP);
    cmp_flag  = is_cmp & (eq_chain ^ cmp_inv);
    carry_out = (kind == K_ARITH) & top_carry;
    result    = slice_r;
    if (is_cmp) begin
      result    = '0;
      result[0] = cmp_flag;
    end
  end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import bsalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         cmp_flag
);

  ctrl_t        ctrl;
  logic [W:0]   carry_c;
  logic [W:0]   eq_c;
  logic [W-1:0] slice_r;

  bsalu_decode u_dec (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  assign carry_c[0] = ctrl.inv_b;
  assign eq_c[0]    = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_slice
    bsalu_slice u_slice (
      .a_bit     (opnd_a[i]),
      .b_bit     (opnd_b[i]),
      .kind      (ctrl.kind),
      .inv_b     (ctrl.inv_b),
      .lfn       (ctrl.lfn),
      .carry_in  (carry_c[i]),
      .eq_in     (eq_c[i]),
      .r_bit     (slice_r[i]),
      .carry_nxt (carry_c[i+1]),
      .eq_nxt    (eq_c[i+1])
    );
  end

  bsalu_finish #(.W(W)) u_fin (
    .kind      (ctrl.kind),
    .cmp_inv   (ctrl.cmp_inv),
    .slice_r   (slice_r),
    .top_carry (carry_c[W]),
    .eq_chain  (eq_c[W]),
    .result    (result),
    .carry_out (carry_out),
    .cmp_flag  (cmp_flag)
  );

endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
  parameter int W = 8
) (
  input logic [2:0]   op_code,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         cmp_flag
);

  always_comb begin
    if (op_code == 3'b001)
      a_r1_add_sum: assert ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}));
    if (op_code == 3'b101) begin
      a_r2_sub_diff:   assert (result == W'(opnd_a - opnd_b));
      a_r2_sub_borrow: assert (carry_out == (opnd_a >= opnd_b));
    end
    if (op_code == 3'b010) a_r3_and: assert (result == (opnd_a & opnd_b));
    if (op_code == 3'b011) a_r3_or:  assert (result == (opnd_a | opnd_b));
    if (op_code == 3'b110) a_r4_nor:  assert (result == ~(opnd_a | opnd_b));
    if (op_code == 3'b111) a_r4_nand: assert (result == ~(opnd_a & opnd_b));
    if (op_code == 3'b100) begin
      a_r5_eq_flag: assert (cmp_flag == (opnd_a == opnd_b));
      a_r5_eq_word: assert (result == W'(opnd_a == opnd_b));
    end
    if (op_code == 3'b000) begin
      a_r6_neq_flag: assert (cmp_flag == (opnd_a != opnd_b));
      a_r6_neq_word: assert (result == W'(opnd_a != opnd_b));
    end
    if (op_code != 3'b001 && op_code != 3'b101)
      a_r7_no_carry: assert (carry_out == 1'b0);
    if (op_code != 3'b000 && op_code != 3'b100)
      a_r8_no_flag: assert (cmp_flag == 1'b0);
  end

endmodule

bind bitslice_alu bitslice_alu_chk #(.W(W)) u_chk (
  .op_code   (op_code),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .result    (result),
  .carry_out (carry_out),
  .cmp_flag  (cmp_flag)
);

// File: tb/sim_bitslice_alu.sv
module sim_bitslice_alu;

  localparam int W = 8;
  localparam int NV = 12;

  // {op[2:0], a[7:0], b[7:0], exp_result[7:0], exp_carry, exp_flag}
  localparam logic [28:0] VEC [NV] = '{
    {3'b001, 8'h0F, 8'h01, 8'h10, 1'b0, 1'b0},
    {3'b001, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0},
    {3'b101, 8'h10, 8'h01, 8'h0F, 1'b1, 1'b0},
    {3'b101, 8'h00, 8'h01, 8'hFF, 1'b0, 1'b0},
    {3'b010, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0},
    {3'b011, 8'hF0, 8'h3C, 8'hFC, 1'b0, 1'b0},
    {3'b110, 8'hF0, 8'h3C, 8'h03, 1'b0, 1'b0},
    {3'b111, 8'hF0, 8'h3C, 8'hCF, 1'b0, 1'b0},
    {3'b100, 8'hA5, 8'hA5, 8'h01, 1'b0, 1'b1},
    {3'b100, 8'hA5, 8'hA4, 8'h00, 1'b0, 1'b0},
    {3'b000, 8'hA5, 8'hA4, 8'h01, 1'b0, 1'b1},
    {3'b000, 8'h80, 8'h80, 8'h00, 1'b0, 1'b0}
  };

  logic         clk;
  logic         rst_n;
  logic [2:0]   op_code;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [W-1:0] result;
  logic         carry_out;
  logic         cmp_flag;

  int  n_chk;
  int  n_fail;
  bit  done;

  bitslice_alu #(.W(W)) u0 (
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .carry_out (carry_out),
    .cmp_flag  (cmp_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'b001: return "R1";
      3'b101: return "R2";
      3'b010, 3'b011: return "R3";
      3'b110, 3'b111: return "R4";
      3'b100: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Independent model: {result, carry, flag}
  function automatic logic [W+1:0] model(input logic [2:0] op,
                                         input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    int unsigned ai = a;
    int unsigned bi = b;
    int unsigned full;
    logic [W-1:0] r = '0;
    logic c = 1'b0;
    logic f = 1'b0;
    case (op)
      3'b001: begin full = ai + bi; r = full[W-1:0]; c = full[W]; end
      3'b101: begin full = ai - bi; r = full[W-1:0]; c = (ai >= bi); end
      3'b010: r = a & b;
      3'b011: r = a | b;
      3'b110: r = ~(a | b);
      3'b111: r = ~(a & b);
      3'b100: begin f = (ai == bi); r = W'(f); end
      default: begin f = (ai != bi); r = W'(f); end
    endcase
    return {r, c, f};
  endfunction

  task automatic apply(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    @(negedge clk);
    op_code = op;
    opnd_a  = a;
    opnd_b  = b;
    #2;
  endtask

  task automatic check(input string req, input logic [W-1:0] er,
                       input logic ec, input logic ef);
    n_chk++;
    if (result !== er || carry_out !== ec || cmp_flag !== ef) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h got r=%h c=%b f=%b exp r=%h c=%b f=%b",
               req, op_code, opnd_a, opnd_b, result, carry_out, cmp_flag,
               er, ec, ef);
    end
  endtask

  task automatic run_model(input logic [2:0] op, input logic [W-1:0] a,
                           input logic [W-1:0] b, input string req);
    logic [W+1:0] e;
    e = model(op, a, b);
    apply(op, a, b);
    check(req, e[W+1:2], e[1], e[0]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    op_code = 3'b000; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    #2;
    // Idle state: NEQ on equal zero operands gives all zeros (R6).
    check("R6 reset", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][28:26], VEC[i][25:18], VEC[i][17:10]);
      check(tag_of(VEC[i][28:26]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R1 full ripple through every slice
    run_model(3'b001, 8'hFF, 8'hFF, "R1 max");
    run_model(3'b001, 8'h80, 8'h80, "R1 top carry");
    // R2 borrow boundary
    run_model(3'b101, 8'h7F, 8'h7F, "R2 equal");
    run_model(3'b101, 8'h7F, 8'h80, "R2 borrow");
    // R5/R6 differences only at the chain ends
    run_model(3'b100, 8'h00, 8'h80, "R5 top bit");
    run_model(3'b100, 8'h01, 8'h00, "R5 low bit");
    run_model(3'b000, 8'h7F, 8'hFF, "R6 top bit");
    run_model(3'b000, 8'hFF, 8'hFF, "R6 equal ones");
    // R7: carry would be 1 if leaked
    run_model(3'b010, 8'hFF, 8'hFF, "R7 and");
    run_model(3'b111, 8'hFF, 8'hFF, "R7 nand");
    run_model(3'b100, 8'hFF, 8'hFF, "R7 eq");
    // R8: equal operands would raise a leaked flag
    run_model(3'b001, 8'h5A, 8'h5A, "R8 add");
    run_model(3'b011, 8'h00, 8'h00, "R8 or");
    run_model(3'b110, 8'h33, 8'h33, "R8 nor");

    for (int k = 0; k < 1600; k++) begin
      logic [2:0]   op = 3'(k % 8);
      logic [W-1:0] a  = W'($urandom);
      logic [W-1:0] b  = (k % 5 == 0) ? a : W'($urandom);
      run_model(op, a, b, tag_of(op));
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

endmodule